// File: doc/BRIEF.md
# Per-Window Time-of-Flight Histogrammer

This block builds a time-of-flight histogram for one detector across one helicity window. A start strobe marks the beginning of each beam pulse, which lasts 32 ns. A hit carries a fine time code that gives its position inside that pulse, in 250 ps steps, so there are 128 bins. Each accepted hit adds one to the counter of its bin. Every beam pulse in the window, on the order of a million of them, adds into the same set of counters.

The counters sit in two banks. While one bank collects, the other holds the previous window. A window-end strobe swaps the two banks. The frozen bank is then streamed out bin by bin over a valid/ready port, and each counter is cleared as it is read. To limit dead time, a pulse that contains an accepted hit blocks all coding during the next pulse. Hits that arrive while the gate is closed are thrown away and counted on their own counter.

Top module: `tof_hist`

## Requirements
- R1: After reset, rd_valid is low, rej_count is zero, and every counter in both banks reads zero.
- R2: A hit is accepted when hit_valid is high, gate_valid is high and the pulse is not blocked. An accepted hit adds one to the counter at index hit_bin (0 to 127, one step per 250 ps of the 32 ns pulse) in the collecting bank. Several accepted hits in one pulse each count.
- R3: Hits to the same bin in back-to-back cycles all count, with none lost.
- R4: A pulse runs from the cycle where pulse_start is high up to the cycle before the next pulse_start. A hit in the same cycle as pulse_start belongs to the new pulse. If a pulse holds at least one accepted hit, every hit in the pulse that follows it is dropped. After that following pulse, coding resumes.
- R5: A hit with gate_valid low is dropped and adds one to rej_count, which saturates at all ones. A dropped hit does not block the next pulse.
- R6: A counter that holds its maximum value (2^CNT_W-1) stays there when further hits arrive.
- R7: mps_end while no readout is running swaps the banks. In the next cycle rd_valid is high with rd_bin 0. A hit accepted in the same cycle as mps_end counts in the new window.
- R8: The readout steps rd_bin from 0 to 127, one bin per cycle in which rd_valid and rd_ready are both high. While rd_ready is low, rd_bin and rd_count hold. rd_valid falls in the cycle after the handshake on bin 127.
- R9: Each bin is cleared when it is read, so a bank starts its next collecting window at zero.
- R10: mps_end during a readout is ignored. The readout carries on, and hits keep adding into the same collecting bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulse_start | input | 1 | Start reference of a beam pulse |
| hit_valid | input | 1 | A hit is present this cycle |
| hit_bin | input | 7 | Fine time code of the hit |
| gate_valid | input | 1 | Acceptance gate for hits |
| mps_end | input | 1 | End of a helicity window |
| rd_ready | input | 1 | Consumer takes the current bin |
| rd_valid | output | 1 | Readout word is present |
| rd_bin | output | 7 | Bin index of the readout word |
| rd_count | output | 24 | Count of that bin in the frozen bank |
| rej_count | output | 16 | Hits dropped because the gate was closed |

## Verification
A hit reaches its counter two clock edges after it is sampled. That is earlier than any readout can see it, so every count is checked through the readout port after a later mps_end. rd_valid and rd_bin 0 are due one edge after mps_end. Each following bin is due one edge after a handshake. rej_count moves one edge after a gated-off hit. The bench drives inputs and samples outputs on the falling edge, so every value it compares has settled at least half a cycle after the rising edge that produced it. Stalls are inserted on alternate bins to confirm that the readout word holds.

// File: rtl/tof_pkg.sv
package tof_pkg;
   typedef enum logic {
      RD_IDLE = 1'b0,
      RD_BUSY = 1'b1
   } rd_state_e;

   localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/tof_gate.sv
module tof_gate #(
   parameter int unsigned REJ_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pulse_start,
   input  logic             hit_valid,
   input  logic             gate_valid,
   output logic             hit_acc,
   output logic [REJ_W-1:0] rej_count
);
   logic armed;    // current pulse already holds an accepted hit
   logic blocked;  // current pulse is neutralized
   logic in_block;

   assign in_block = pulse_start ? armed : blocked;
   assign hit_acc  = hit_valid & gate_valid & ~in_block;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         blocked <= 1'b0;
      end else if (pulse_start) begin
         blocked <= armed;
         armed   <= hit_acc;
      end else begin
         armed   <= armed | hit_acc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rej_count <= '0;
      else if (hit_valid && !gate_valid && (rej_count != {REJ_W{1'b1}}))
         rej_count <= rej_count + 1'b1;
   end
endmodule

// File: rtl/tof_bank_store.sv
module tof_bank_store #(
   parameter int unsigned BINS  = 128,
   parameter int unsigned BIN_W = 7,
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_v,
   input  logic             inc_bank,
   input  logic [BIN_W-1:0] inc_bin,
   input  logic             clr_v,
   input  logic             rd_bank,
   input  logic [BIN_W-1:0] rd_bin,
   output logic [CNT_W-1:0] rd_cnt
);
   import tof_pkg::*;

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [NUM_BANKS-1:0][CNT_W-1:0] look_q;
   logic [NUM_BANKS-1:0][CNT_W-1:0] out_q;

   // update pipeline: stage 1 holds the captured hit and its read value
   logic             s1_v;
   logic             s1_bank;
   logic [BIN_W-1:0] s1_bin;
   logic [CNT_W-1:0] s1_old;
   logic             s1_fwd;
   logic [CNT_W-1:0] last_wr;
   logic [CNT_W-1:0] base;
   logic [CNT_W-1:0] wr_data;

   assign base    = s1_fwd ? last_wr : s1_old;
   assign wr_data = (base == CNT_MAX) ? base : base + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_bank <= 1'b0;
         s1_bin  <= '0;
         s1_old  <= '0;
         s1_fwd  <= 1'b0;
         last_wr <= '0;
      end else begin
         s1_v    <= inc_v;
         s1_bank <= inc_bank;
         s1_bin  <= inc_bin;
         s1_old  <= look_q[inc_bank];
         s1_fwd  <= s1_v && (s1_bank == inc_bank) && (s1_bin == inc_bin);
         if (s1_v)
            last_wr <= wr_data;
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [CNT_W-1:0] cells [BINS];
      logic             wr_here;
      logic             clr_here;

      assign wr_here  = s1_v && (s1_bank == 1'(b));
      assign clr_here = clr_v && (rd_bank == 1'(b));
      assign look_q[b] = cells[inc_bin];
      assign out_q[b]  = cells[rd_bin];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < BINS; i++)
               cells[i] <= '0;
         end else begin
            if (wr_here)
               cells[s1_bin] <= wr_data;
            if (clr_here)
               cells[rd_bin] <= '0;
         end
      end
   end

   assign rd_cnt = out_q[rd_bank];
endmodule

// File: rtl/tof_readout.sv
module tof_readout #(
   parameter int unsigned BINS  = 128,
   parameter int unsigned BIN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mps_end,
   input  logic             rd_ready,
   output logic             rd_valid,
   output logic [BIN_W-1:0] rd_bin,
   output logic             act_bank,
   output logic             swap,
   output logic             clr_v
);
   import tof_pkg::*;

   localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(BINS - 1);

   rd_state_e state;

   assign rd_valid = (state == RD_BUSY);
   assign swap     = mps_end && (state == RD_IDLE);
   assign clr_v    = rd_valid && rd_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RD_IDLE;
         rd_bin   <= '0;
         act_bank <= 1'b0;
      end else begin
         if (swap) begin
            state    <= RD_BUSY;
            rd_bin   <= '0;
            act_bank <= ~act_bank;
         end else if (clr_v) begin
            rd_bin <= rd_bin + 1'b1;
            if (rd_bin == LAST_BIN)
               state <= RD_IDLE;
         end
      end
   end
endmodule

// File: rtl/tof_hist.sv
module tof_hist #(
   parameter int unsigned BINS  = 128,
   parameter int unsigned CNT_W = 24,
   parameter int unsigned REJ_W = 16,
   localparam int unsigned BIN_W = $clog2(BINS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pulse_start,
   input  logic             hit_valid,
   input  logic [BIN_W-1:0] hit_bin,
   input  logic             gate_valid,
   input  logic             mps_end,
   input  logic             rd_ready,
   output logic             rd_valid,
   output logic [BIN_W-1:0] rd_bin,
   output logic [CNT_W-1:0] rd_count,
   output logic [REJ_W-1:0] rej_count
);
   if (BINS < 2 || (1 << BIN_W) != BINS) begin : g_bins_chk
      $error("tof_hist: BINS must be a power of two of at least 2");
   end
   if (CNT_W < 2) begin : g_cnt_chk
      $error("tof_hist: CNT_W must be at least 2");
   end
   if (REJ_W < 1) begin : g_rej_chk
      $error("tof_hist: REJ_W must be at least 1");
   end

   logic hit_acc;
   logic act_bank;
   logic swap;
   logic clr_v;
   logic inc_bank;

   // a hit in the swap cycle already belongs to the new window
   assign inc_bank = swap ? ~act_bank : act_bank;

   tof_gate #(.REJ_W(REJ_W)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .pulse_start (pulse_start),
      .hit_valid   (hit_valid),
      .gate_valid  (gate_valid),
      .hit_acc     (hit_acc),
      .rej_count   (rej_count)
   );

   tof_readout #(.BINS(BINS), .BIN_W(BIN_W)) u_readout (
      .clk      (clk),
      .rst_n    (rst_n),
      .mps_end  (mps_end),
      .rd_ready (rd_ready),
      .rd_valid (rd_valid),
      .rd_bin   (rd_bin),
      .act_bank (act_bank),
      .swap     (swap),
      .clr_v    (clr_v)
   );

   tof_bank_store #(.BINS(BINS), .BIN_W(BIN_W), .CNT_W(CNT_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_v    (hit_acc),
      .inc_bank (inc_bank),
      .inc_bin  (hit_bin),
      .clr_v    (clr_v),
      .rd_bank  (~act_bank),
      .rd_bin   (rd_bin),
      .rd_cnt   (rd_count)
   );
endmodule

// File: rtl/tof_hist_chk.sv
module tof_hist_chk #(
   parameter int unsigned BIN_W = 7,
   parameter int unsigned CNT_W = 24,
   parameter int unsigned REJ_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hit_valid,
   input logic             gate_valid,
   input logic             mps_end,
   input logic             rd_ready,
   input logic             rd_valid,
   input logic [BIN_W-1:0] rd_bin,
   input logic [CNT_W-1:0] rd_count,
   input logic [REJ_W-1:0] rej_count
);
   localparam logic [BIN_W-1:0] LAST = {BIN_W{1'b1}};
   localparam logic [REJ_W-1:0] RMAX = {REJ_W{1'b1}};

   AST_READ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      mps_end && !rd_valid |=> rd_valid && (rd_bin == '0)); // R7

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_bin) && $stable(rd_count)); // R8

   AST_BIN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && rd_ready && (rd_bin != LAST) |=> rd_valid && (rd_bin == BIN_W'($past(rd_bin) + 1'b1))); // R8

   AST_READ_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && rd_ready && (rd_bin == LAST) |=> !rd_valid); // R8

   AST_END_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && mps_end && !rd_ready |=> rd_valid && $stable(rd_bin)); // R10

   AST_REJ_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid && !gate_valid && (rej_count != RMAX) |=> rej_count == REJ_W'($past(rej_count) + 1'b1)); // R5

   AST_REJ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_valid && !gate_valid) |=> $stable(rej_count)); // R5
endmodule

bind tof_hist tof_hist_chk #(.BIN_W(BIN_W), .CNT_W(CNT_W), .REJ_W(REJ_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hit_valid  (hit_valid),
   .gate_valid (gate_valid),
   .mps_end    (mps_end),
   .rd_ready   (rd_ready),
   .rd_valid   (rd_valid),
   .rd_bin     (rd_bin),
   .rd_count   (rd_count),
   .rej_count  (rej_count)
);

// File: tb/test_tof_hist.sv
module test_tof_hist;
   localparam int BINS  = 128;
   localparam int BIN_W = 7;
   localparam int CNT_W = 4;   // small width so saturation is reachable
   localparam int REJ_W = 16;
   localparam int CMAX  = (1 << CNT_W) - 1;

   // {bin[6:0], hits[3:0]}
   localparam logic [10:0] VEC [8] = '{
      {7'd0,   4'd1}, {7'd127, 4'd2}, {7'd5,  4'd3}, {7'd64, 4'd1},
      {7'd5,   4'd2}, {7'd100, 4'd4}, {7'd1,  4'd1}, {7'd127, 4'd1}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pulse_start = 1'b0;
   logic             hit_valid = 1'b0;
   logic [BIN_W-1:0] hit_bin = '0;
   logic             gate_valid = 1'b1;
   logic             mps_end = 1'b0;
   logic             rd_ready = 1'b0;
   logic             rd_valid;
   logic [BIN_W-1:0] rd_bin;
   logic [CNT_W-1:0] rd_count;
   logic [REJ_W-1:0] rej_count;

   int errors = 0;
   int checks = 0;
   int exp_cnt [BINS];

   always #4 clk = ~clk;

   tof_hist #(.BINS(BINS), .CNT_W(CNT_W), .REJ_W(REJ_W)) i_tof_hist (
      .clk, .rst_n, .pulse_start, .hit_valid, .hit_bin, .gate_valid,
      .mps_end, .rd_ready, .rd_valid, .rd_bin, .rd_count, .rej_count
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic idle_pulse();
      pulse_start = 1'b1; cyc();
      pulse_start = 1'b0; cyc(); cyc();
   endtask

   task automatic hit_one(input int b);
      idle_pulse(); idle_pulse();
      pulse_start = 1'b1; cyc();
      pulse_start = 1'b0;
      hit_valid = 1'b1; hit_bin = BIN_W'(b); cyc();
      hit_valid = 1'b0; cyc();
   endtask

   task automatic add_hit(input int b);
      exp_cnt[b] = (exp_cnt[b] >= CMAX) ? CMAX : exp_cnt[b] + 1;
   endtask

   // walks the frozen bank; inject=1 exercises R10 during the walk
   task automatic read_all(input string req, input bit inject);
      for (int i = 0; i < BINS; i++) begin
         chk(rd_valid && rd_bin == BIN_W'(i) && int'(rd_count) == exp_cnt[i],
             $sformatf("%s bin %0d", req, i), int'(rd_count), exp_cnt[i]);
         if (inject && i == 50) begin
            mps_end = 1'b1; cyc(); mps_end = 1'b0;
            chk(rd_valid && rd_bin == 7'd50, "R10 readout continues", int'(rd_bin), 50);
         end
         if (inject && i == 60) begin
            idle_pulse(); idle_pulse();
            pulse_start = 1'b1; cyc(); pulse_start = 1'b0;
            hit_valid = 1'b1; hit_bin = 7'd30; cyc(); cyc();
            hit_valid = 1'b0; cyc();
            chk(rd_bin == 7'd60, "R8 held during stall", int'(rd_bin), 60);
         end
         if (i % 2 == 1) begin
            cyc();
            chk(rd_valid && rd_bin == BIN_W'(i) && int'(rd_count) == exp_cnt[i],
                "R8 stall holds word", int'(rd_count), exp_cnt[i]);
         end
         rd_ready = 1'b1; cyc(); rd_ready = 1'b0;
      end
      chk(!rd_valid, "R8 valid falls after last bin", int'(rd_valid), 0);
      for (int i = 0; i < BINS; i++) exp_cnt[i] = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      for (int i = 0; i < BINS; i++) exp_cnt[i] = 0;
      cyc(); cyc();
      chk(!rd_valid, "R1 rd_valid low in reset", int'(rd_valid), 0);
      rst_n = 1'b1; cyc();
      chk(!rd_valid, "R1 rd_valid low after reset", int'(rd_valid), 0);
      chk(rej_count == 0, "R1 rej_count zero", int'(rej_count), 0);

      // R2 table of hits
      for (int k = 0; k < 8; k++) begin
         for (int n = 0; n < int'(VEC[k][3:0]); n++) begin
            hit_one(int'(VEC[k][10:4]));
            add_hit(int'(VEC[k][10:4]));
         end
      end

      // R3 back-to-back hits to one bin, then a two-apart repeat
      idle_pulse(); idle_pulse();
      pulse_start = 1'b1; cyc(); pulse_start = 1'b0;
      hit_valid = 1'b1; hit_bin = 7'd5; cyc(); cyc(); cyc();
      hit_bin = 7'd6; cyc();
      hit_bin = 7'd5; cyc();
      hit_valid = 1'b0; cyc();
      add_hit(5); add_hit(5); add_hit(5); add_hit(5); add_hit(6);

      // R4 neutralization: hit on the start cycle, blocked pulse, recovery
      idle_pulse(); idle_pulse();
      pulse_start = 1'b1; hit_valid = 1'b1; hit_bin = 7'd10; cyc();
      pulse_start = 1'b0; hit_valid = 1'b0; cyc();
      pulse_start = 1'b1; hit_valid = 1'b1; hit_bin = 7'd11; cyc();
      pulse_start = 1'b0; cyc();
      hit_valid = 1'b0; cyc();
      pulse_start = 1'b1; cyc();
      pulse_start = 1'b0; hit_valid = 1'b1; hit_bin = 7'd12; cyc();
      hit_valid = 1'b0; cyc();
      add_hit(10); add_hit(12);

      // R5 gate closed: dropped, counted, no neutralization
      idle_pulse(); idle_pulse();
      pulse_start = 1'b1; cyc(); pulse_start = 1'b0;
      gate_valid = 1'b0; hit_valid = 1'b1; hit_bin = 7'd20; cyc(); cyc(); cyc();
      gate_valid = 1'b1; hit_valid = 1'b0;
      chk(rej_count == 3, "R5 rejected hits counted", int'(rej_count), 3);
      pulse_start = 1'b1; cyc(); pulse_start = 1'b0;
      hit_valid = 1'b1; hit_bin = 7'd21; cyc();
      hit_valid = 1'b0; cyc();
      add_hit(21);
      chk(rej_count == 3, "R5 rej_count steady", int'(rej_count), 3);

      // R6 saturation
      for (int n = 0; n < 20; n++) begin
         hit_one(9);
         add_hit(9);
      end
      chk(exp_cnt[9] == CMAX, "R6 model saturates", exp_cnt[9], CMAX);

      // R7 swap, R8 walk, R10 ignored end with hits into the collecting bank
      mps_end = 1'b1; cyc(); mps_end = 1'b0;
      chk(rd_valid && rd_bin == 0, "R7 readout starts at bin 0", int'(rd_bin), 0);
      read_all("R2", 1'b1);

      // R9 cleared on read; R7 hit in the swap cycle lands in the new window
      exp_cnt[30] = 2;
      idle_pulse(); idle_pulse();
      pulse_start = 1'b1; mps_end = 1'b1; hit_valid = 1'b1; hit_bin = 7'd31; cyc();
      pulse_start = 1'b0; mps_end = 1'b0; hit_valid = 1'b0;
      read_all("R9", 1'b0);

      exp_cnt[31] = 1;
      mps_end = 1'b1; cyc(); mps_end = 1'b0;
      read_all("R7", 1'b0);

      // R1 the other bank started empty and is now empty again
      mps_end = 1'b1; cyc(); mps_end = 1'b0;
      read_all("R1", 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule